// File: doc/BRIEF.md
# Serial Command Frame Engine

This block is the serial front end of a small register-controlled device. It works as an SPI mode-0 slave. While chip select is low it takes one input bit on each rising serial clock and puts one output bit on each falling serial clock, most significant bit first. The input bits form 16-bit frames. Each frame is an instruction byte followed by a data byte. The instruction byte carries a 3-bit opcode and a 5-bit register address.

When chip select rises, the engine decodes the last 16 bits it received. If they hold an operation, it gives the opcode, the effective address and the data to the register block as a one-cycle strobe in the system clock domain. The serial clock, chip select and data input are synchronised into that domain first.

The output pin repeats the bits received 16 serial clocks earlier, so several devices can share one chip select with their data lines chained. A read is answered in the frame that follows it. The outgoing register is loaded with the echoed instruction byte and the byte the register block returns. The output can be configured as push-pull or open-drain, and it floats whenever chip select is high.

Top module: `spi_cmd_frame_engine`

## Requirements
- R1: Input bits are taken on rising serial clock edges, most significant bit first. The output bit changes only on a falling serial clock edge or on the chip-select falling edge, and never on a rising edge.
- R2: In a frame, bits 15:13 are the opcode, bits 12:8 are the address and bits 7:0 are the data. The strobe presents these three fields.
- R3: Opcode 001 (control read), 011 (control write), 100 (addressed read) and 110 (addressed write) produce a strobe. Opcode 000 (no-op) and every other code produce none.
- R4: For the two control opcodes, the address field is ignored and the strobe presents address 10h.
- R5: A command executes only after chip select rises. The strobe `cmd_valid` is high for exactly one system clock.
- R6: Only the last 16 bits clocked in before chip select rises are decoded. A select period with fewer than 16 rising serial clock edges produces no strobe.
- R7: After reset, nothing is shifted or executed until a falling edge of chip select is seen. A frame clocked while chip select was already low at reset is ignored.
- R8: `sdo_oe` is low while chip select is high and before the block is armed. In push-pull mode it is high while a frame is in progress.
- R9: With `sdo_od_mode`=1 the pin is driven only when the bit is 0. `sdo_out` is then 0 and `sdo_oe` equals the inverse of the bit.
- R10: After a non-read frame, the output carries the bits received 16 rising serial clocks earlier. This holds across frame boundaries, which lets devices be chained.
- R11: After a read, the next frame shifts out the read's instruction byte, as received, followed by `rd_data`. `rd_data` is sampled in the cycle the strobe is high.
- R12: During and after reset, `cmd_valid` and `sdo_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_in | input | 1 | Serial clock, asynchronous |
| csn_in | input | 1 | Chip select, active low, asynchronous |
| sdi_in | input | 1 | Serial data in |
| sdo_od_mode | input | 1 | 0 selects push-pull output, 1 selects open-drain |
| rd_data | input | 8 | Read value returned by the register block during the strobe |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 3 | Decoded opcode |
| cmd_addr | output | 5 | Effective register address |
| cmd_data | output | 8 | Data byte of the frame |
| sdo_out | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Serial data out enable |

## Verification
The hardest state to reach is the output register after a read. It holds a mix of the echoed instruction byte and the returned data, and it only shows up in the frame that follows. The bench therefore sweeps every opcode against every address back to back, and it predicts each frame's output from the frame before it. Every read is checked by the frame that follows it, and every non-read by its echo. A cold start with chip select already low, a short frame, an over-long frame and a two-frame chained transfer reach the arming and last-16-bits rules.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NOP    = 3'b000,
        OP_CTL_RD = 3'b001,
        OP_CTL_WR = 3'b011,
        OP_REG_RD = 3'b100,
        OP_REG_WR = 3'b110
    } op_e;

    function automatic logic op_is_ctl(input logic [OP_W-1:0] op);
        return (op == OP_CTL_RD) || (op == OP_CTL_WR);
    endfunction

    function automatic logic op_is_read(input logic [OP_W-1:0] op);
        return (op == OP_CTL_RD) || (op == OP_REG_RD);
    endfunction

    // Operation that reaches the register block (no-op excluded)
    function automatic logic op_is_cmd(input logic [OP_W-1:0] op);
        return op_is_ctl(op) || (op == OP_REG_RD) || (op == OP_REG_WR);
    endfunction
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_a,
    input  logic csn_a,
    input  logic sdi_a,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic csn_lvl,
    output logic sdi_lvl
);
    localparam int LANES = 3;
    localparam int EDGE_LANES = 2;

    logic [LANES-1:0] raw;
    logic [LANES-1:0] lvl;
    logic [EDGE_LANES-1:0] prev_d, prev_q;

    assign raw = {sdi_a, csn_a, sck_a};

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [STAGES-1:0] ch_d, ch_q;
            always_comb begin
                ch_d = {ch_q[STAGES-2:0], raw[g]};
            end
            // Reset to 0 so a select held low through reset is no falling edge
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ch_q <= '0;
                else        ch_q <= ch_d;
            end
            assign lvl[g] = ch_q[STAGES-1];
        end
    endgenerate

    always_comb begin
        prev_d = lvl[EDGE_LANES-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign sck_rise = lvl[0] & ~prev_q[0];
    assign sck_fall = ~lvl[0] & prev_q[0];
    assign cs_rise  = lvl[1] & ~prev_q[1];
    assign cs_fall  = ~lvl[1] & prev_q[1];
    assign csn_lvl  = lvl[1];
    assign sdi_lvl  = lvl[2];
endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift #(
    parameter int FRAME = 16,
    parameter int CNT_W = $clog2(FRAME + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_rise,
    input  logic             sck_fall,
    input  logic             cs_fall,
    input  logic             csn_lvl,
    input  logic             sdi_lvl,
    input  logic             load_en,
    input  logic [FRAME-1:0] load_val,
    output logic [FRAME-1:0] frame_q,
    output logic             full,
    output logic             out_bit,
    output logic             armed
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME);

    typedef struct packed {
        logic [FRAME-1:0] sh;
        logic [CNT_W-1:0] cnt;
        logic             out;
        logic             armed;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cs_fall) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
            st_d.out   = st_q.sh[FRAME-1];
        end else if (!csn_lvl && st_q.armed) begin
            if (sck_rise) begin
                st_d.sh = {st_q.sh[FRAME-2:0], sdi_lvl};
                if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
            end
            if (sck_fall) st_d.out = st_q.sh[FRAME-1];
        end
        if (load_en) st_d.sh = load_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_q = st_q.sh;
    assign full    = (st_q.cnt == CNT_MAX);
    assign out_bit = st_q.out;
    assign armed   = st_q.armed;
endmodule

// File: rtl/spi_fe_decode.sv
module spi_fe_decode
    import spi_fe_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int ADDR_W   = BYTE_W - OP_W,
    parameter int ACR_ADDR = 16
) (
    input  logic [2*BYTE_W-1:0] frame,
    output logic [OP_W-1:0]     op,
    output logic [ADDR_W-1:0]   addr,
    output logic [BYTE_W-1:0]   data,
    output logic [BYTE_W-1:0]   instr,
    output logic                is_cmd,
    output logic                is_read
);
    localparam int FRAME = 2 * BYTE_W;

    always_comb begin
        instr   = frame[FRAME-1 -: BYTE_W];
        op      = instr[BYTE_W-1 -: OP_W];
        data    = frame[BYTE_W-1:0];
        addr    = op_is_ctl(op) ? ADDR_W'(ACR_ADDR) : instr[ADDR_W-1:0];
        is_cmd  = op_is_cmd(op);
        is_read = op_is_read(op);
    end
endmodule

// File: rtl/spi_cmd_frame_engine.sv
module spi_cmd_frame_engine
    import spi_fe_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ACR_ADDR    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sck_in,
    input  logic                     csn_in,
    input  logic                     sdi_in,
    input  logic                     sdo_od_mode,
    input  logic [BYTE_W-1:0]        rd_data,
    output logic                     cmd_valid,
    output logic [OP_W-1:0]          cmd_op,
    output logic [BYTE_W-OP_W-1:0]   cmd_addr,
    output logic [BYTE_W-1:0]        cmd_data,
    output logic                     sdo_out,
    output logic                     sdo_oe
);
    localparam int ADDR_W = BYTE_W - OP_W;
    localparam int FRAME  = 2 * BYTE_W;

    logic sck_rise, sck_fall, cs_fall, cs_rise, csn_lvl, sdi_lvl;
    logic [FRAME-1:0] frame_q;
    logic full, out_bit, armed;
    logic load_en;
    logic [FRAME-1:0] load_val;
    logic [OP_W-1:0] dec_op;
    logic [ADDR_W-1:0] dec_addr;
    logic [BYTE_W-1:0] dec_data, dec_instr;
    logic dec_cmd, dec_read;

    typedef struct packed {
        logic              valid;
        logic              rd;
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] instr;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    spi_fe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sck_a(sck_in), .csn_a(csn_in), .sdi_a(sdi_in),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise),
        .csn_lvl(csn_lvl), .sdi_lvl(sdi_lvl)
    );

    spi_fe_shift #(.FRAME(FRAME)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_fall(cs_fall), .csn_lvl(csn_lvl), .sdi_lvl(sdi_lvl),
        .load_en(load_en), .load_val(load_val),
        .frame_q(frame_q), .full(full), .out_bit(out_bit), .armed(armed)
    );

    spi_fe_decode #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .ACR_ADDR(ACR_ADDR)) u_dec (
        .frame(frame_q), .op(dec_op), .addr(dec_addr), .data(dec_data),
        .instr(dec_instr), .is_cmd(dec_cmd), .is_read(dec_read)
    );

    always_comb begin
        cmd_d       = cmd_q;
        cmd_d.valid = cs_rise && armed && full && dec_cmd;
        if (cmd_d.valid) begin
            cmd_d.rd    = dec_read;
            cmd_d.op    = dec_op;
            cmd_d.addr  = dec_addr;
            cmd_d.data  = dec_data;
            cmd_d.instr = dec_instr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    // Read answer is placed in the outgoing register during the strobe
    assign load_en  = cmd_q.valid && cmd_q.rd;
    assign load_val = {cmd_q.instr, rd_data};

    assign cmd_valid = cmd_q.valid;
    assign cmd_op    = cmd_q.op;
    assign cmd_addr  = cmd_q.addr;
    assign cmd_data  = cmd_q.data;

    assign sdo_out = sdo_od_mode ? 1'b0 : out_bit;
    assign sdo_oe  = !csn_lvl && armed && (!sdo_od_mode || !out_bit);
endmodule

// File: rtl/spi_fe_checker.sv
module spi_fe_checker #(
    parameter int ADDR_W   = 5,
    parameter int ACR_ADDR = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              sdo_out,
    input logic              sdo_oe,
    input logic              sdo_od_mode,
    input logic              csn_lvl,
    input logic              armed,
    input logic              cs_rise,
    input logic              cs_fall,
    input logic              sck_fall,
    input logic              out_bit
);
    assert_out_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_bit) |-> $past(sck_fall || cs_fall));

    assert_op_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op == 3'b001 || cmd_op == 3'b011 ||
                       cmd_op == 3'b100 || cmd_op == 3'b110));

    assert_ctl_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'b001 || cmd_op == 3'b011)) |-> cmd_addr == ADDR_W'(ACR_ADDR));

    assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_after_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(cs_rise));

    assert_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> armed);

    assert_float_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_lvl || !armed) |-> !sdo_oe);

    assert_open_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_od_mode && sdo_oe) |-> !sdo_out);
endmodule

bind spi_cmd_frame_engine spi_fe_checker #(.ADDR_W(ADDR_W), .ACR_ADDR(ACR_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
    .sdo_od_mode(sdo_od_mode), .csn_lvl(csn_lvl), .armed(armed),
    .cs_rise(cs_rise), .cs_fall(cs_fall), .sck_fall(sck_fall), .out_bit(out_bit)
);

// File: tb/sim_spi_cmd_frame_engine.sv
module sim_spi_cmd_frame_engine;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, csn = 1'b0, sdi = 1'b0, od = 1'b0;
    logic [7:0] rd_data;
    logic cmd_valid, sdo_out, sdo_oe;
    logic [2:0] cmd_op;
    logic [4:0] cmd_addr;
    logic [7:0] cmd_data;

    int checks = 0, errors = 0;
    int cap_n = 0;
    logic [2:0] cap_op;
    logic [4:0] cap_addr;
    logic [7:0] cap_data;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign rd_data = 8'hC3 ^ {3'b000, cmd_addr};

    spi_cmd_frame_engine u0 (
        .clk(clk), .rst_n(rst_n), .sck_in(sck), .csn_in(csn), .sdi_in(sdi),
        .sdo_od_mode(od), .rd_data(rd_data), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .sdo_out(sdo_out), .sdo_oe(sdo_oe)
    );

    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            cap_n    <= cap_n + 1;
            cap_op   <= cmd_op;
            cap_addr <= cmd_addr;
            cap_data <= cmd_data;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic pin();
        return sdo_oe ? sdo_out : 1'b1;
    endfunction

    task automatic xfer(input logic [31:0] tx, input int n, output logic [31:0] rx);
        logic b;
        rx = '0;
        csn = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sdi = tx[n-1-i];
            repeat (6) @(negedge clk);
            if (!od) check(sdo_oe == 1'b1, "R8 drive", 32'(sdo_oe), 1);
            else if (sdo_oe) check(sdo_out == 1'b0, "R9 od", 32'(sdo_out), 0);
            b = pin();
            rx = {rx[30:0], b};
            sck = 1'b1;
            repeat (5) @(negedge clk);
            check(pin() == b, "R1 edge", 32'(pin()), 32'(b));
            @(negedge clk);
            sck = 1'b0;
        end
        repeat (6) @(negedge clk);
        csn = 1'b1;
        repeat (14) @(negedge clk);
        check(sdo_oe == 1'b0, "R8 idle", 32'(sdo_oe), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rx;
        logic [15:0] exp_next;
        int n0;
        // R12: reset with select held low
        repeat (3) @(negedge clk);
        check(cmd_valid == 1'b0, "R12 valid", 32'(cmd_valid), 0);
        check(sdo_oe == 1'b0, "R12 oe", 32'(sdo_oe), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(sdo_oe == 1'b0, "R12 oe after", 32'(sdo_oe), 0);

        // R7: frame while select was low from reset is ignored
        for (int i = 0; i < 16; i++) begin
            sdi = 1'(16'hC155 >> (15 - i));
            repeat (6) @(negedge clk);
            check(sdo_oe == 1'b0, "R8 unarmed", 32'(sdo_oe), 0);
            sck = 1'b1; repeat (6) @(negedge clk); sck = 1'b0;
        end
        repeat (6) @(negedge clk);
        csn = 1'b1;
        repeat (14) @(negedge clk);
        check(cap_n == 0, "R7 no cmd", cap_n, 0);

        // R6: short frame is discarded; nothing was shifted before arming
        xfer(32'h0ABC, 12, rx);
        check(rx[11:0] == 12'h000, "R7 no shift", rx[11:0], 0);
        check(cap_n == 0, "R6 short", cap_n, 0);

        // R6: over-long frame executes its last 16 bits
        xfer({12'h0, 4'hF, 16'hC23C}, 20, rx);
        check(rx[19:4] == 16'h0ABC, "R10 echo long", rx[19:4], 32'h0ABC);
        check(rx[3:0] == 4'hF, "R10 echo tail", rx[3:0], 32'hF);
        check(cap_n == 1, "R6 long count", cap_n, 1);
        check({cap_op, cap_addr, cap_data} == 16'hC23C, "R6 long fields",
              {cap_op, cap_addr, cap_data}, 32'hC23C);
        exp_next = 16'hC23C;

        // R2 R3 R4 R10 R11: every opcode against every address
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 32; a++) begin
                logic [7:0] d;
                logic [4:0] ea;
                bit cmd, rd;
                d   = 8'(op * 37 + a * 5);
                cmd = (op == 1 || op == 3 || op == 4 || op == 6);
                rd  = (op == 1 || op == 4);
                ea  = (op == 1 || op == 3) ? 5'h10 : 5'(a);
                n0  = cap_n;
                xfer({16'h0, 3'(op), 5'(a), d}, 16, rx);
                check(rx[15:0] == exp_next, "R10 R11 sdo", rx[15:0], 32'(exp_next));
                check(cap_n == n0 + (cmd ? 1 : 0), "R3 count", cap_n - n0, cmd ? 1 : 0);
                if (cmd) begin
                    check(cap_op == 3'(op), "R2 op", cap_op, op);
                    check(cap_addr == ea, "R4 addr", cap_addr, 32'(ea));
                    check(cap_data == d, "R2 data", cap_data, 32'(d));
                end
                exp_next = rd ? {3'(op), 5'(a), 8'hC3 ^ {3'b000, ea}} : {3'(op), 5'(a), d};
            end
        end

        // R9: open-drain output reads back through a pull-up
        od = 1'b1;
        xfer(32'h0000, 16, rx);
        check(rx[15:0] == exp_next, "R9 od data", rx[15:0], 32'(exp_next));
        od = 1'b0;
        exp_next = 16'h0000;

        // R10: two chained frames in one select; R6 last frame executes
        n0 = cap_n;
        xfer(32'hC511C733, 32, rx);
        check(rx[31:16] == 16'h0000, "R10 chain head", rx[31:16], 0);
        check(rx[15:0] == 16'hC511, "R10 chain pass", rx[15:0], 32'hC511);
        check(cap_n == n0 + 1, "R5 one strobe", cap_n - n0, 1);
        check({cap_op, cap_addr, cap_data} == 16'hC733, "R6 chain last",
              {cap_op, cap_addr, cap_data}, 32'hC733);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule